// File: doc/BRIEF.md
# Processor Reset-Cause and Run-Control Register

This block is the 8-bit status and control register that a small microcontroller core reads and writes through its I/O space. It keeps a record of why the core last restarted: a power-on, a watchdog timeout, or an SE0 bus reset seen on the upstream USB port. It also holds the run and suspend controls, and it shows the live interrupt-enable state and an interrupt-pending flag.

Each reset source loads its own pattern. A watchdog restart keeps the earlier power-on and bus-reset flags, so firmware can still tell the causes apart. A HALT clears the whole register and freezes it until a hard reset. A suspend request is dropped while the bus is active. An SE0 only counts as a bus reset once it has lasted a parameterised number of clock cycles.

Top module: `cpu_stat_ctl`

## Requirements
- R1: Bit positions are: run at 0, reserved at 1, interrupt-enable sense at 2, suspend at 3, power-on flag at 4, bus-reset flag at 5, watchdog flag at 6, IRQ pending at 7. Asserting por_n low loads 8'h11 asynchronously. `halted` equals the inverse of bit 0, and `suspended` equals bit 3.
- R2: A wdt_rst cycle loads bit 6 = 1 and bit 0 = 1. It clears bits 7, 3, 2 and 1 and the saved interrupt-enable copy. Bits 5 and 4 keep their earlier values. It takes priority over every event except por_n.
- R3: A halt_stb cycle while running clears all eight bits. While bit 0 is 0, writes, interrupt strobes and SE0 leave the register unchanged until wdt_rst or por_n.
- R4: Bit 2 is set by ei_stb and cleared by di_stb. irq_take copies bit 2 into a saved copy and clears bit 2. reti_stb restores bit 2 from that copy. The order of precedence is take, reti, di, ei. Firmware writes to bit 2 have no effect.
- R5: Bit 1 always reads 0, and firmware writes to bit 7 have no effect.
- R6: A firmware write (wr_en) stores wr_data bits 0, 4, 5 and 6 into the same bit positions, so firmware can clear the power-on and bus-reset flags.
- R7: A write with wr_data bit 3 = 1 sets suspend only if bus_active is low in that cycle. Otherwise suspend stays clear.
- R8: While suspended, bus_active, or irq_seen with bit 2 = 1, clears suspend on the next edge.
- R9: Bit 5 sets on the clock edge that samples the SE0_MIN-th consecutive cycle with both usb_dp and usb_dm low. A shorter SE0 does not set it, and one long SE0 produces one detection.
- R10: irq_seen sets bit 7 and irq_take clears it. When both occur in the same cycle, bit 7 ends up set.
- R11: When a hardware set of bit 5 or bit 7 coincides with a firmware write of 0 to that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset request, one cycle |
| halt_stb | input | 1 | HALT executed |
| ei_stb | input | 1 | Enable-interrupts instruction |
| di_stb | input | 1 | Disable-interrupts instruction |
| reti_stb | input | 1 | Return-from-interrupt instruction |
| irq_seen | input | 1 | An interrupt has been recognised |
| irq_take | input | 1 | Interrupt vector taken |
| usb_dp | input | 1 | Upstream D+ level |
| usb_dm | input | 1 | Upstream D- level |
| bus_active | input | 1 | USB bus activity present |
| wr_en | input | 1 | Firmware write to the register |
| wr_data | input | 8 | Firmware write data |
| rd_data | output | 8 | Register readback |
| halted | output | 1 | Core stopped (run bit clear) |
| suspended | output | 1 | Low-power suspend active |

## Verification
Every field of the register appears directly on rd_data, so a wrong internal state shows up one edge after the event that causes it. Examples are a watchdog pattern that drops the power-on flag or a suspend bit that survives bus activity. The state the bench cannot see directly is the SE0 run-length counter and the saved enable copy. A wrong counter shows as bit 5 setting one cycle early or late at the SE0_MIN boundary. A wrong saved copy shows on the first reti_stb, when bit 2 comes back with the wrong value.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
    localparam int REG_W = 8;

    // register-held control and flag fields (bit 2 and bit 1 are not stored here)
    typedef struct packed {
        logic irq_pend;
        logic wdr;
        logic busrst;
        logic porf;
        logic susp;
        logic run;
    } ctl_t;

    localparam ctl_t CTL_POR = '{irq_pend: 1'b0, wdr: 1'b0, busrst: 1'b0,
                                 porf: 1'b1, susp: 1'b0, run: 1'b1};

    function automatic logic [REG_W-1:0] pack_rd(ctl_t c, logic ie);
        return {c.irq_pend, c.wdr, c.busrst, c.porf, c.susp, ie, 1'b0, c.run};
    endfunction
endpackage

// File: rtl/cs_se0_qual.sv
`timescale 1ns/1ps
module cs_se0_qual #(
    parameter int SE0_MIN = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic usb_dp,
    input  logic usb_dm,
    output logic hit
);
    localparam int CW = $clog2(SE0_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(SE0_MIN - 1);
    localparam logic [CW-1:0] SAT  = CW'(SE0_MIN);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          se0;

    always_comb begin
        se0   = ~usb_dp & ~usb_dm;
        hit   = se0 && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!se0)
            cnt_d = '0;
        else if (cnt_q != SAT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: one long SE0 gives only one detection pulse
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!por_n)
        hit |=> !hit);
endmodule

// File: rtl/cs_ie_track.sv
`timescale 1ns/1ps
module cs_ie_track (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic hold,
    input  logic ei_stb,
    input  logic di_stb,
    input  logic reti_stb,
    input  logic irq_take,
    output logic ie
);
    typedef struct packed {
        logic ie;
        logic saved;
    } ie_t;

    ie_t ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        if (clr) begin
            ie_d = '0;
        end else if (!hold) begin
            if (irq_take) begin
                ie_d.saved = ie_q.ie;
                ie_d.ie    = 1'b0;
            end else if (reti_stb) begin
                ie_d.ie = ie_q.saved;
            end else if (di_stb) begin
                ie_d.ie = 1'b0;
            end else if (ei_stb) begin
                ie_d.ie = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

    assign ie = ie_q.ie;

    // R4: a lone EI on a running core enables interrupts
    a_r4_ei_sets: assert property (@(posedge clk) disable iff (!por_n)
        (ei_stb && !di_stb && !reti_stb && !irq_take && !hold && !clr) |=> ie);
    // R4: taking the vector always masks interrupts
    a_r4_take_masks: assert property (@(posedge clk) disable iff (!por_n)
        (irq_take && !hold) |=> !ie);
endmodule

// File: rtl/cpu_stat_ctl.sv
`timescale 1ns/1ps
module cpu_stat_ctl
    import cs_pkg::*;
#(
    parameter int SE0_MIN = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wdt_rst,
    input  logic             halt_stb,
    input  logic             ei_stb,
    input  logic             di_stb,
    input  logic             reti_stb,
    input  logic             irq_seen,
    input  logic             irq_take,
    input  logic             usb_dp,
    input  logic             usb_dm,
    input  logic             bus_active,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             halted,
    output logic             suspended
);
    ctl_t ctl_d, ctl_q;
    logic se0_hit;
    logic ie;

    cs_se0_qual #(.SE0_MIN(SE0_MIN)) u_se0 (
        .clk    (clk),
        .por_n  (por_n),
        .usb_dp (usb_dp),
        .usb_dm (usb_dm),
        .hit    (se0_hit)
    );

    cs_ie_track u_ie (
        .clk      (clk),
        .por_n    (por_n),
        .clr      (wdt_rst | (ctl_q.run & halt_stb)),
        .hold     (~ctl_q.run),
        .ei_stb   (ei_stb),
        .di_stb   (di_stb),
        .reti_stb (reti_stb),
        .irq_take (irq_take),
        .ie       (ie)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wdt_rst) begin
            ctl_d          = '0;
            ctl_d.wdr      = 1'b1;
            ctl_d.run      = 1'b1;
            ctl_d.porf     = ctl_q.porf;
            ctl_d.busrst   = ctl_q.busrst;
        end else if (!ctl_q.run) begin
            ctl_d = ctl_q;
        end else if (halt_stb) begin
            ctl_d = '0;
        end else begin
            if (wr_en) begin
                ctl_d.run    = wr_data[0];
                ctl_d.susp   = wr_data[3] & ~bus_active;
                ctl_d.porf   = wr_data[4];
                ctl_d.busrst = wr_data[5];
                ctl_d.wdr    = wr_data[6];
            end
            if (ctl_q.susp && (bus_active || (irq_seen && ie)))
                ctl_d.susp = 1'b0;
            if (irq_take) ctl_d.irq_pend = 1'b0;
            if (irq_seen) ctl_d.irq_pend = 1'b1;
            if (se0_hit)  ctl_d.busrst   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= CTL_POR;
        else        ctl_q <= ctl_d;
    end

    assign rd_data   = pack_rd(ctl_q, ie);
    assign halted    = ~ctl_q.run;
    assign suspended = ctl_q.susp;

    // R2: watchdog pattern keeps power-on and bus-reset flags
    a_r2_wdt_pattern: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst |=> (rd_data[7] == 1'b0) && rd_data[6] && (rd_data[3:1] == 3'b000)
                    && rd_data[0] && (rd_data[5:4] == $past(rd_data[5:4])));
    // R3: halted register is frozen unless the watchdog fires
    a_r3_halt_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (halted && !wdt_rst) |=> ($stable(rd_data) && halted));
    // R5: reserved bit never reads one
    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[1] == 1'b0);
    // R7: suspend request is refused while the bus is busy
    a_r7_susp_refused: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_data[3] && bus_active) |=> !suspended);
    // R8: bus activity ends suspend
    a_r8_wake_bus: assert property (@(posedge clk) disable iff (!por_n)
        (suspended && bus_active) |=> !suspended);
    // R9: qualified SE0 sets the bus-reset flag on a running core
    a_r9_se0_flag: assert property (@(posedge clk) disable iff (!por_n)
        (se0_hit && !halted && !wdt_rst && !halt_stb) |=> rd_data[5]);
    // R10 / R11: recognised interrupt always leaves pending set
    a_r10_pend_set: assert property (@(posedge clk) disable iff (!por_n)
        (irq_seen && !halted && !wdt_rst && !halt_stb) |=> rd_data[7]);
endmodule

// File: tb/cpu_stat_ctl_tb.sv
`timescale 1ns/1ps
module cpu_stat_ctl_tb;
    localparam int SE0_MIN = 16;
    localparam int NV = 18;
    // {wr_en, wr_data, ei, di, reti, seen, take, bus_active, expected rd_data}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 8'h00, 6'b000000, 8'h11},  // R1 idle after power-on
        {1'b1, 8'hF7, 6'b000000, 8'h71},  // R5 R6 bits 7,2,1 ignored
        {1'b1, 8'h01, 6'b000000, 8'h01},  // R6 clear flags
        {1'b0, 8'h00, 6'b100000, 8'h05},  // R4 EI
        {1'b0, 8'h00, 6'b000100, 8'h85},  // R10 recognised
        {1'b0, 8'h00, 6'b000010, 8'h01},  // R4 R10 take
        {1'b0, 8'h00, 6'b001000, 8'h05},  // R4 RETI restores
        {1'b0, 8'h00, 6'b010000, 8'h01},  // R4 DI
        {1'b1, 8'h09, 6'b000001, 8'h01},  // R7 refused while busy
        {1'b1, 8'h09, 6'b000000, 8'h09},  // R7 accepted
        {1'b0, 8'h00, 6'b000000, 8'h09},  // R7 stays
        {1'b0, 8'h00, 6'b000001, 8'h01},  // R8 bus wake
        {1'b0, 8'h00, 6'b100000, 8'h05},  // R4 EI
        {1'b1, 8'h09, 6'b000000, 8'h0D},  // R4 bit2 write ignored
        {1'b0, 8'h00, 6'b000100, 8'h85},  // R8 interrupt wake
        {1'b0, 8'h00, 6'b000110, 8'h81},  // R10 set wins over take
        {1'b0, 8'h00, 6'b001000, 8'h85},  // R4 RETI
        {1'b0, 8'h00, 6'b000010, 8'h01}   // R10 take
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wdt_rst = 1'b0, halt_stb = 1'b0;
    logic       ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0;
    logic       irq_seen = 1'b0, irq_take = 1'b0;
    logic       usb_dp = 1'b1, usb_dm = 1'b0, bus_active = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       halted, suspended;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_stat_ctl #(.SE0_MIN(SE0_MIN)) u_dut (
        .clk(clk), .por_n(por_n), .wdt_rst(wdt_rst), .halt_stb(halt_stb),
        .ei_stb(ei_stb), .di_stb(di_stb), .reti_stb(reti_stb),
        .irq_seen(irq_seen), .irq_take(irq_take),
        .usb_dp(usb_dp), .usb_dm(usb_dm), .bus_active(bus_active),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .halted(halted), .suspended(suspended)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_data = 8'h00; wdt_rst = 1'b0; halt_stb = 1'b0;
        ei_stb = 1'b0; di_stb = 1'b0; reti_stb = 1'b0;
        irq_seen = 1'b0; irq_take = 1'b0; bus_active = 1'b0;
        usb_dp = 1'b1; usb_dm = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d; tick(); idle();
    endtask

    task automatic se0(int n);
        for (int i = 0; i < n; i++) begin
            usb_dp = 1'b0; usb_dm = 1'b0; tick();
        end
        usb_dp = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, 8'h11);
        chk("R1 halted/suspended at reset", {6'd0, halted, suspended}, 8'h00);
        por_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wr_en = VEC[v][22]; wr_data = VEC[v][21:14];
            ei_stb = VEC[v][13]; di_stb = VEC[v][12]; reti_stb = VEC[v][11];
            irq_seen = VEC[v][10]; irq_take = VEC[v][9]; bus_active = VEC[v][8];
            tick();
            chk($sformatf("R4-R10 vector %0d", v), rd_data, VEC[v][7:0]);
            idle();
        end

        // R9: short SE0 ignored, SE0_MIN cycles set the flag
        se0(SE0_MIN - 1); tick();
        chk("R9 short SE0", rd_data, 8'h01);
        se0(SE0_MIN);
        chk("R9 qualified SE0", rd_data, 8'h21);
        wr(8'h01);
        chk("R6 clear bus flag", rd_data, 8'h01);

        // R11: hardware set beats a firmware clear in the same cycle
        se0(SE0_MIN - 1);
        usb_dp = 1'b0; wr_en = 1'b1; wr_data = 8'h01; tick(); idle();
        chk("R11 set beats write", rd_data, 8'h21);
        wr(8'h01);

        // R2: watchdog keeps earlier flags, clears the rest
        wr(8'h31);
        ei_stb = 1'b1; tick(); idle();
        irq_seen = 1'b1; tick(); idle();
        wr(8'h39);
        chk("R2 setup", rd_data, 8'hBD);
        wdt_rst = 1'b1; tick(); idle();
        chk("R2 watchdog pattern", rd_data, 8'h71);
        chk("R2 suspend cleared", {7'd0, suspended}, 8'h00);
        reti_stb = 1'b1; tick(); idle();
        chk("R2 saved enable cleared", rd_data, 8'h71);

        // R3: HALT clears and freezes
        wr(8'h01);
        halt_stb = 1'b1; tick(); idle();
        chk("R3 halt clears", rd_data, 8'h00);
        chk("R3 halted out", {7'd0, halted}, 8'h01);
        wr(8'hFF);
        ei_stb = 1'b1; irq_seen = 1'b1; tick(); idle();
        se0(SE0_MIN + 2); tick();
        chk("R3 frozen while halted", rd_data, 8'h00);
        wdt_rst = 1'b1; tick(); idle();
        chk("R3 watchdog restarts", rd_data, 8'h41);
        chk("R3 running again", {7'd0, halted}, 8'h00);

        // R1: power-on mid-run
        wr(8'h61);
        por_n = 1'b0; #1;
        chk("R1 async power-on", rd_data, 8'h11);
        @(negedge clk); por_n = 1'b1; @(negedge clk);
        chk("R1 after power-on release", rd_data, 8'h11);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule